// File: doc/BRIEF.md
# I2C Command-Stepped Bus Master

This block drives an I2C bus one step at a time under software control. Software writes a command into the control register: a START, a STOP, or a one-byte transfer whose direction follows the last address byte. The engine runs that single bus step, raises a done flag and leaves a numeric result code in the status register. Software reads the code, chooses the next step and launches it by writing a 1 to the done bit. Each step is driven and acknowledged on its own; there is no fixed transaction sequence.

The SCL rate comes from an 8-bit rate register and a 2-bit prescaler select. Both bus lines are open-drain: an output of 1 releases the line, and 0 pulls it low. The master reads SDA back to sample ACK bits and received data, and to detect a lost arbitration. The register port is a plain write strobe and the register contents are always visible on outputs. No data stream crosses the block's edge, so no valid/ready handshake or back-pressure applies.

Register map (reg_addr):
- 0 is control.
- 1 is the rate value BR.
- 2 is the prescaler select; only bits 1:0 are kept.
- 3 is the data byte.

Top module: `i2c_cmd_master`

## Requirements
- R1: After reset both bus lines are released (1), ctrl_o is 0x00, status_o is 0xF8 (code 0x1F, prescaler select 0) and data_o is 0x00.
- R2: Each SCL half-period lasts H = 8 + BR·P clocks, where P is 1, 4, 16 or 64 for prescaler select 0, 1, 2 or 3. The SCL period is therefore 16 + 2·BR·P clocks.
- R3: A START command (control bit 5) behaves as follows:
  - SDA falls while SCL is high.
  - The step ends with SCL held low and the done flag set.
  - The status code is 0x08 when the bus was free and 0x10 (repeated START) when the master already held it.
- R4: The first byte after a START is an address byte, sent MSB first. Bit 0 of that byte selects the direction: 0 gives status 0x18 on ACK or 0x20 on NACK; 1 gives status 0x40 on ACK or 0x48 on NACK. An ACK is SDA sampled low in the ninth clock.
- R5: A later byte, sent after a write-direction address, gives status 0x28 on ACK and 0x30 on NACK.
- R6: After a read-direction address, a byte command receives 8 bits MSB first into the data register. In the ninth clock the master pulls SDA low when enable-ACK (control bit 6) is 1, giving status 0x50. It releases SDA when that bit is 0, giving status 0x58.
- R7: A STOP command (control bit 4) behaves as follows:
  - SDA rises while SCL is high and both lines are left released.
  - Bit 4 clears itself and the done flag is not set.
  - When bit 5 is also set, a START (code 0x08) follows directly.
- R8: Writing control with bit 7 = 1 clears the done flag. If bit 2 (enable) is also 1 in that write, one step is launched. The done flag (bit 7) is set when a START or byte step completes. irq_o equals done AND bit 0 (interrupt enable).
- R9: A write to the data register while the done flag is 0 sets the collision flag (control bit 3) and leaves data_o unchanged. A write while done is 1 loads the byte and clears bit 3.
- R10: If the master releases SDA for a 1 bit while transmitting and samples SDA low, it reports status 0x38, sets done and releases both lines.
- R11: SDA changes only while SCL is low, except the falling edge of a START and the rising edge of a STOP.
- R12: Writing control with bit 2 = 0 abandons any step and releases both lines on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 rate, 2 prescaler select, 3 data |
| reg_wdata | input | 8 | Register write value |
| ctrl_o | output | 8 | Control: done(7) ack-enable(6) start(5) stop(4) collision(3) enable(2) zero(1) irq-enable(0) |
| status_o | output | 8 | Result code in bits 7:3, zero in bit 2, prescaler select in bits 1:0 |
| data_o | output | 8 | Data byte: next byte to send, or last byte received |
| irq_o | output | 1 | Done AND interrupt enable |
| scl_o | output | 1 | SCL drive: 1 releases, 0 pulls low |
| sda_o | output | 1 | SDA drive: 1 releases, 0 pulls low |
| sda_i | input | 1 | SDA line as seen on the bus |

## Verification
A behavioural slave on the open-drain lines is set to acknowledge or refuse, and it returns a fixed byte in read direction. Each result code comes from a distinct input pattern:
- Write and read addresses, each acknowledged and refused, separate the address codes from the data codes.
- Received bytes with enable-ACK on and off separate 0x50 from 0x58; the bench also observes the ACK bit the slave actually sees.
- A START from a free bus, a repeated START and a STOP chained into a START separate 0x08 from 0x10.

Further cases cover the remaining rules:
- The SCL high time is measured at two rate settings to confirm the half-period formula.
- A line forced low during a 1 bit provokes the arbitration code.
- Counting SDA edges seen while SCL is high shows exactly one such edge for a START and none inside a byte.

// File: rtl/i2cm_pkg.sv
`timescale 1ns/1ps
package i2cm_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {ST_IDLE, ST_START, ST_BYTE, ST_STOP} i2cm_state_e;

  // result codes, upper five bits of the status register
  localparam logic [4:0] CODE_NONE    = 5'h1F;  // 0xF8
  localparam logic [4:0] CODE_START   = 5'h01;  // 0x08
  localparam logic [4:0] CODE_RSTART  = 5'h02;  // 0x10
  localparam logic [4:0] CODE_AW_ACK  = 5'h03;  // 0x18
  localparam logic [4:0] CODE_AW_NACK = 5'h04;  // 0x20
  localparam logic [4:0] CODE_TX_ACK  = 5'h05;  // 0x28
  localparam logic [4:0] CODE_TX_NACK = 5'h06;  // 0x30
  localparam logic [4:0] CODE_ARB     = 5'h07;  // 0x38
  localparam logic [4:0] CODE_AR_ACK  = 5'h08;  // 0x40
  localparam logic [4:0] CODE_AR_NACK = 5'h09;  // 0x48
  localparam logic [4:0] CODE_RX_ACK  = 5'h0A;  // 0x50
  localparam logic [4:0] CODE_RX_NACK = 5'h0B;  // 0x58
endpackage

// File: rtl/i2cm_rate.sv
`timescale 1ns/1ps
module i2cm_rate #(
  parameter int BR_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic [BR_W-1:0] br,
  input  logic [1:0]      psel,
  output logic            tick1,
  output logic            half_end
);
  localparam int CNT_W = BR_W + 7;

  logic [CNT_W-1:0] half;
  logic [CNT_W-1:0] cnt;

  assign half     = CNT_W'(8) + (CNT_W'(br) << {psel, 1'b0});
  assign half_end = run && (cnt == half - CNT_W'(1));
  assign tick1    = run && (cnt == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (!run)     cnt <= '0;
    else if (half_end) cnt <= '0;
    else               cnt <= cnt + CNT_W'(1);
  end

  // R2: the phase counter never passes the programmed half-period
  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt < half));
endmodule

// File: rtl/i2cm_engine.sv
`timescale 1ns/1ps
module i2cm_engine
  import i2cm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              launch,
  input  logic              cmd_sta,
  input  logic              cmd_sto,
  input  logic              ack_en,
  input  logic [BYTE_W-1:0] tx_byte,
  input  logic              sda_i,
  input  logic              tick1,
  input  logic              half_end,
  output logic              busy,
  output logic              fin,
  output logic [4:0]        fin_code,
  output logic              rx_load,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              stop_fin,
  output logic              scl_o,
  output logic              sda_o
);
  i2cm_state_e       state;
  logic [4:0]        idx;
  logic [BYTE_W-1:0] sh;
  logic              owned, addr_next, rd_mode, is_addr, chain_sta;
  logic [3:0]        bitn;
  logic              bit_low, is_rx, ack_seen;
  logic [4:0]        byte_code;

  assign bitn     = idx[4:1];
  assign bit_low  = ~idx[0];
  assign is_rx    = rd_mode & ~is_addr;
  assign busy     = (state != ST_IDLE);
  assign rx_byte  = sh;
  assign ack_seen = ~sda_i;

  always_comb begin
    if (is_addr)
      byte_code = sh[0] ? (ack_seen ? CODE_AR_ACK : CODE_AR_NACK)
                        : (ack_seen ? CODE_AW_ACK : CODE_AW_NACK);
    else if (is_rx)
      byte_code = ack_en ? CODE_RX_ACK : CODE_RX_NACK;
    else
      byte_code = ack_seen ? CODE_TX_ACK : CODE_TX_NACK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE; idx <= '0; sh <= '0;
      owned <= 1'b0; addr_next <= 1'b0; rd_mode <= 1'b0;
      is_addr <= 1'b0; chain_sta <= 1'b0;
      scl_o <= 1'b1; sda_o <= 1'b1;
      fin <= 1'b0; fin_code <= CODE_NONE; rx_load <= 1'b0; stop_fin <= 1'b0;
    end else begin
      fin <= 1'b0; rx_load <= 1'b0; stop_fin <= 1'b0;
      if (!en) begin
        state <= ST_IDLE; owned <= 1'b0; scl_o <= 1'b1; sda_o <= 1'b1;
      end else begin
        case (state)
          ST_IDLE: if (launch) begin
            idx <= '0;
            if (cmd_sto) begin
              chain_sta <= cmd_sta;
              if (owned) state <= ST_STOP;
              else begin
                stop_fin <= 1'b1;
                if (cmd_sta) begin state <= ST_START; idx <= 5'd1; end
              end
            end else if (cmd_sta) begin
              state <= ST_START;
              idx   <= owned ? 5'd0 : 5'd1;
            end else begin
              state   <= ST_BYTE;
              scl_o   <= 1'b0;
              sh      <= tx_byte;
              is_addr <= addr_next;
            end
          end
          ST_START: begin
            if (tick1 && idx == 5'd0) sda_o <= 1'b1;
            if (half_end) begin
              idx <= idx + 5'd1;
              case (idx)
                5'd0:    scl_o <= 1'b1;
                5'd1:    sda_o <= 1'b0;
                default: begin
                  scl_o <= 1'b0; owned <= 1'b1; addr_next <= 1'b1;
                  fin <= 1'b1; fin_code <= owned ? CODE_RSTART : CODE_START;
                  state <= ST_IDLE;
                end
              endcase
            end
          end
          ST_BYTE: begin
            if (bit_low) begin
              if (tick1)
                sda_o <= (bitn < 4'd8) ? (is_rx | sh[7]) : (is_rx ? ~ack_en : 1'b1);
              if (half_end) begin scl_o <= 1'b1; idx <= idx + 5'd1; end
            end else if (half_end) begin
              if (bitn < 4'd8 && !is_rx && sh[7] && !sda_i) begin
                sda_o <= 1'b1; scl_o <= 1'b1; owned <= 1'b0; addr_next <= 1'b0;
                fin <= 1'b1; fin_code <= CODE_ARB; state <= ST_IDLE;
              end else if (bitn < 4'd8) begin
                sh <= {sh[BYTE_W-2:0], sda_i}; scl_o <= 1'b0; idx <= idx + 5'd1;
              end else begin
                scl_o <= 1'b0; fin <= 1'b1; fin_code <= byte_code;
                addr_next <= 1'b0; rx_load <= is_rx; state <= ST_IDLE;
                if (is_addr) rd_mode <= sh[0];
              end
            end
          end
          ST_STOP: begin
            if (tick1 && idx == 5'd0) sda_o <= 1'b0;
            if (half_end) begin
              idx <= idx + 5'd1;
              case (idx)
                5'd0:    scl_o <= 1'b1;
                5'd1:    sda_o <= 1'b1;
                default: begin
                  owned <= 1'b0; stop_fin <= 1'b1;
                  if (chain_sta) begin state <= ST_START; idx <= 5'd1; end
                  else state <= ST_IDLE;
                end
              endcase
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  // R11: an SDA edge with SCL high on both sides only comes from START, STOP or disable
  p_sda_low_only_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_o && $past(scl_o) && (sda_o != $past(sda_o))) |->
      ($past(state) == ST_START || $past(state) == ST_STOP || !$past(en)));
endmodule

// File: rtl/i2c_cmd_master.sv
`timescale 1ns/1ps
module i2c_cmd_master
  import i2cm_pkg::*;
#(
  parameter int BR_W = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_we,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] ctrl_o,
  output logic [7:0] status_o,
  output logic [7:0] data_o,
  output logic       irq_o,
  output logic       scl_o,
  output logic       sda_o,
  input  logic       sda_i
);
  localparam logic [1:0] A_CTRL = 2'd0, A_RATE = 2'd1, A_PSEL = 2'd2, A_DATA = 2'd3;

  logic            done_q, ea_q, sta_q, sto_q, wcol_q, en_q, ie_q;
  logic [BR_W-1:0] br_q;
  logic [1:0]      psel_q;
  logic [4:0]      code_q;
  logic [7:0]      data_q;
  logic            wr_ctrl, wr_data, en_nx, launch;
  logic            busy, fin, rx_load, stop_fin, tick1, half_end;
  logic [4:0]      fin_code;
  logic [7:0]      rx_byte;

  assign wr_ctrl = reg_we && (reg_addr == A_CTRL);
  assign wr_data = reg_we && (reg_addr == A_DATA);
  assign en_nx   = wr_ctrl ? reg_wdata[2] : en_q;
  assign launch  = wr_ctrl && reg_wdata[7] && reg_wdata[2] && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0; ea_q <= 1'b0; sta_q <= 1'b0; sto_q <= 1'b0;
      wcol_q <= 1'b0; en_q <= 1'b0; ie_q <= 1'b0;
      br_q <= '0; psel_q <= '0; code_q <= CODE_NONE; data_q <= '0;
    end else begin
      if (wr_ctrl) begin
        ea_q <= reg_wdata[6]; sta_q <= reg_wdata[5]; sto_q <= reg_wdata[4];
        en_q <= reg_wdata[2]; ie_q <= reg_wdata[0];
        if (reg_wdata[7]) done_q <= 1'b0;
      end
      if (stop_fin) sto_q <= 1'b0;
      if (fin) begin done_q <= 1'b1; code_q <= fin_code; end
      if (reg_we && reg_addr == A_RATE) br_q <= BR_W'(reg_wdata);
      if (reg_we && reg_addr == A_PSEL) psel_q <= reg_wdata[1:0];
      if (rx_load) data_q <= rx_byte;
      else if (wr_data) begin
        if (done_q) begin data_q <= reg_wdata; wcol_q <= 1'b0; end
        else wcol_q <= 1'b1;
      end
    end
  end

  assign ctrl_o   = {done_q, ea_q, sta_q, sto_q, wcol_q, en_q, 1'b0, ie_q};
  assign status_o = {code_q, 1'b0, psel_q};
  assign data_o   = data_q;
  assign irq_o    = done_q & ie_q;

  i2cm_rate #(.BR_W(BR_W)) u_rate (
    .clk(clk), .rst_n(rst_n), .run(busy), .br(br_q), .psel(psel_q),
    .tick1(tick1), .half_end(half_end));

  i2cm_engine u_engine (
    .clk(clk), .rst_n(rst_n), .en(en_nx), .launch(launch),
    .cmd_sta(reg_wdata[5]), .cmd_sto(reg_wdata[4]), .ack_en(ea_q),
    .tx_byte(data_q), .sda_i(sda_i), .tick1(tick1), .half_end(half_end),
    .busy(busy), .fin(fin), .fin_code(fin_code), .rx_load(rx_load),
    .rx_byte(rx_byte), .stop_fin(stop_fin), .scl_o(scl_o), .sda_o(sda_o));

  // R9: a data write that collides leaves the data register untouched
  p_wcol_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_data) && !$past(done_q) && !$past(rx_load)) |-> (data_q == $past(data_q)));

  // R7: when the stop request clears itself, the done flag stays low
  p_stop_no_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sto_q) && !$past(wr_ctrl)) |-> !done_q);
endmodule

// File: tb/i2c_cmd_master_bench.sv
`timescale 1ns/1ps
module i2c_cmd_master_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] ctrl_o, status_o, data_o;
  logic       irq_o, scl_o, sda_o;

  int checks = 0;
  int errors = 0;

  // behavioural slave on the open-drain lines
  logic       s_rel = 1'b1, force_low = 1'b0, slave_ack = 1'b1;
  logic       s_rd = 1'b0, s_isaddr = 1'b0, mack = 1'b1;
  int         s_bit = 0;
  logic [7:0] s_sh = 8'd0, s_txb = 8'h3B, s_addr = 8'd0, s_data = 8'd0;
  wire        sda_line = sda_o & s_rel & ~force_low;

  localparam logic [7:0] GO = 8'h80, EA = 8'h40, STA = 8'h20, STO = 8'h10, EN = 8'h04, IE = 8'h01;

  always #4 clk = ~clk;

  i2c_cmd_master u_i2c_cmd_master (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .ctrl_o(ctrl_o), .status_o(status_o),
    .data_o(data_o), .irq_o(irq_o), .scl_o(scl_o), .sda_o(sda_o),
    .sda_i(sda_line));

  always @(negedge sda_line) if (scl_o) begin s_bit = 0; s_isaddr = 1'b1; s_rd = 1'b0; end

  always @(posedge scl_o) begin
    if (s_bit < 8) begin
      s_sh = {s_sh[6:0], sda_line};
      if (s_bit == 7) begin
        if (s_isaddr) begin s_addr = s_sh; s_rd = s_sh[0] & slave_ack; end
        else if (!s_rd) s_data = s_sh;
      end
    end else if (s_rd && !s_isaddr) mack = sda_line;
    s_bit++;
  end

  always @(negedge scl_o) begin
    if (s_bit == 9) begin
      if (!s_isaddr && s_rd && mack) s_rd = 1'b0;
      s_bit = 0; s_isaddr = 1'b0;
    end
    if (s_bit == 8) s_rel = (s_isaddr || !s_rd) ? ~slave_ack : 1'b1;
    else if (s_rd && !s_isaddr && s_bit < 8) s_rel = s_txb[7-s_bit];
    else s_rel = 1'b1;
  end

  // counts master SDA edges seen while SCL stays high
  int   hi_edges = 0;
  logic p_scl = 1'b1, p_sda = 1'b1;
  always @(negedge clk) begin
    if (scl_o && p_scl && (sda_o != p_sda)) hi_edges++;
    p_scl = scl_o; p_sda = sda_o;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic wait_done();
    while (!ctrl_o[7]) @(negedge clk);
  endtask

  task automatic do_start();
    wr(2'd0, GO | STA | EN | IE); wait_done();
  endtask

  task automatic do_byte(input logic [7:0] b, input logic [7:0] extra);
    wr(2'd3, b); wr(2'd0, GO | EN | IE | extra); wait_done();
  endtask

  task automatic do_stop();
    wr(2'd0, GO | STO | EN | IE);
    while (ctrl_o[4]) @(negedge clk);
  endtask

  task automatic measure_high(output int h);
    h = 0;
    while (scl_o) @(negedge clk);
    while (!scl_o) @(negedge clk);
    while (scl_o) begin h++; @(negedge clk); end
  endtask

  task automatic t_reset();
    check("R1 ctrl", ctrl_o, 8'h00);
    check("R1 status", status_o, 8'hF8);
    check("R1 data", data_o, 8'h00);
    check("R1 lines", {scl_o, sda_o}, 2'b11);
  endtask

  task automatic t_collision();
    wr(2'd3, 8'h77);
    check("R9 collision flag", ctrl_o[3], 1);
    check("R9 data kept", data_o, 8'h00);
  endtask

  task automatic t_write_txn();
    int e0;
    e0 = hi_edges;
    do_start();
    check("R3 start code", status_o[7:3], 5'h01);
    check("R3 scl held low", scl_o, 0);
    check("R8 irq with done", irq_o, 1);
    check("R11 one edge in START", hi_edges - e0, 1);
    wr(2'd3, 8'hA0);
    check("R9 data loaded", data_o, 8'hA0);
    check("R9 collision cleared", ctrl_o[3], 0);
    wr(2'd0, GO | EN | IE);
    check("R8 done cleared by launch", ctrl_o[7], 0);
    check("R8 irq low while busy", irq_o, 0);
    wait_done();
    check("R4 write addr ack code", status_o[7:3], 5'h03);
    check("R4 slave saw address", s_addr, 8'hA0);
    e0 = hi_edges;
    do_byte(8'h5C, 8'h00);
    check("R5 data ack code", status_o[7:3], 5'h05);
    check("R5 slave got byte", s_data, 8'h5C);
    check("R11 no edge inside byte", hi_edges - e0, 0);
    slave_ack = 1'b0;
    do_byte(8'h11, 8'h00);
    check("R5 data nack code", status_o[7:3], 5'h06);
    slave_ack = 1'b1;
  endtask

  task automatic t_read_txn();
    do_start();
    check("R3 repeated start code", status_o[7:3], 5'h02);
    do_byte(8'hA1, 8'h00);
    check("R4 read addr ack code", status_o[7:3], 5'h08);
    wr(2'd0, GO | EN | IE | EA); wait_done();
    check("R6 rx ack code", status_o[7:3], 5'h0A);
    check("R6 rx byte", data_o, 8'h3B);
    check("R6 ack driven", mack, 0);
    wr(2'd0, GO | EN | IE); wait_done();
    check("R6 rx nack code", status_o[7:3], 5'h0B);
    check("R6 nack released", mack, 1);
    do_stop();
    check("R7 done not set", ctrl_o[7], 0);
    check("R7 stop bit cleared", ctrl_o[4], 0);
    check("R7 lines released", {scl_o, sda_o}, 2'b11);
  endtask

  task automatic t_nack_and_chain();
    do_start();
    slave_ack = 1'b0;
    do_byte(8'hA0, 8'h00);
    check("R4 write addr nack code", status_o[7:3], 5'h04);
    do_start();
    do_byte(8'hA1, 8'h00);
    check("R4 read addr nack code", status_o[7:3], 5'h09);
    slave_ack = 1'b1;
    wr(2'd0, GO | STA | STO | EN | IE); wait_done();
    check("R7 chained start code", status_o[7:3], 5'h01);
    check("R7 chained stop cleared", ctrl_o[4], 0);
    do_stop();
  endtask

  task automatic t_rate();
    int h;
    wr(2'd1, 8'd2); wr(2'd2, 8'd1);
    check("R2 prescaler readback", status_o[1:0], 1);
    do_start();
    fork
      do_byte(8'hA0, 8'h00);
      measure_high(h);
    join
    check("R2 high time BR=2 P=4", h, 16);
    wr(2'd1, 8'd0); wr(2'd2, 8'd3);
    fork
      do_byte(8'h44, 8'h00);
      measure_high(h);
    join
    check("R2 high time BR=0 P=64", h, 8);
    do_stop();
    wr(2'd1, 8'd2); wr(2'd2, 8'd0);
  endtask

  task automatic t_arb();
    do_start();
    force_low = 1'b1;
    do_byte(8'hA0, 8'h00);
    check("R10 arbitration code", status_o[7:3], 5'h07);
    check("R10 lines released", {scl_o, sda_o}, 2'b11);
    force_low = 1'b0;
  endtask

  task automatic t_disable();
    do_start();
    check("R12 bus held before disable", scl_o, 0);
    wr(2'd0, 8'h00);
    check("R12 lines released", {scl_o, sda_o}, 2'b11);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual hung expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    wr(2'd1, 8'd2);
    wr(2'd0, EN | IE);
    t_collision();
    t_write_txn();
    t_read_txn();
    t_nack_and_chain();
    t_rate();
    t_arb();
    t_disable();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule